// File: doc/BRIEF.md
# Resynchronizing Asynchronous Serial Receiver

This block receives 8N1 asynchronous frames from a radio link. The line input is already synchronous to the clock and free of bounce. The receiver oversamples it at a fixed rate. A low level marks a start bit and a high level marks a stop bit. Eight data bits arrive between them, least significant bit first. Each completed frame produces one of two one-clock pulses: a byte-valid strobe when the stop bit is good, or a framing-error strobe when it is not.

The recovery after a bad stop bit is fully defined. The receiver reports the error and waits for the line to go high. It then hunts for the next low level at once. A transmitter can use this to move the receiver's byte boundary on purpose. An alternating preamble followed by a short run of chosen bytes drives a misaligned receiver back onto the true frame boundary.

The baud rate comes from two parameters. The number of oversampling ticks per bit is one. A clock divider that makes each tick is the other. A synchronous reset returns the receiver to the hunting state.

Top module: `rf_uart_rx`

## Requirements
- R1: After synchronous reset, `rx_valid` and `rx_frame_err` are low and `rx_byte` is zero. The receiver is hunting, so a frame that starts right after reset is received.
- R2: The eight data bits are sampled at the centre of each bit period and assembled least significant bit first. `rx_byte` holds the last good byte until the next good stop bit.
- R3: A high stop bit pulses `rx_valid` for exactly one clock. With one clock per tick, the pulse comes at clock edge OVS/2 + 9*OVS + 1, counting the edge that first samples the start low as edge 1.
- R4: A low stop bit pulses `rx_frame_err` for exactly one clock. No `rx_valid` pulse occurs for that frame.
- R5: After a framing error, no new frame is started while the line stays low, however long that lasts.
- R6: Once the line is back high after a framing error, hunting resumes on the next tick. A start bit that follows only two clocks of high line is received correctly.
- R7: A low level that is high again at the mid-start sample is ignored as a glitch. The receiver produces no strobe and returns to hunting.
- R8: A receiver released at any bit position inside a preamble of 0x55 bytes is steered onto the true boundary by the byte sequence 0x44, 0x11, 0x45, 0x15. The byte that follows is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Serial line, synchronous, idle high |
| rx_byte | output | NBITS | Last correctly framed byte |
| rx_valid | output | 1 | One-clock strobe for a good frame |
| rx_frame_err | output | 1 | One-clock strobe for a zero stop bit |

## Verification
The bench builds the receiver with OVS = 16 and TICK_DIV = 1, so one bit lasts sixteen clocks and every sample edge can be counted exactly. With a bit this short, all 256 byte values can be swept. The bench also sweeps every release point across the first twenty preamble bits to test the alignment sequence, and still runs a long hold-low recovery and a glitch inside a short run.

// File: rtl/rfrx_pkg.sv
package rfrx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CONFIRM,
    ST_DATA,
    ST_STOP,
    ST_RECOVER
  } rx_state_e;

  // tick count (from 0) at which the start bit is rechecked
  function automatic int mid_tick(input int ovs);
    return ovs / 2 - 1;
  endfunction

  // tick count (from 0) at which a data or stop bit is taken
  function automatic int end_tick(input int ovs);
    return ovs - 1;
  endfunction

endpackage

// File: rtl/rfrx_tick_gen.sv
module rfrx_tick_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (TICK_DIV <= 1) begin : g_every_clock
      assign tick = 1'b1;
    end else begin : g_divider
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          div_cnt <= '0;
        end else if (div_cnt == DW'(TICK_DIV - 1)) begin
          div_cnt <= '0;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end

      assign tick = (div_cnt == DW'(TICK_DIV - 1));

      p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/rfrx_shift.sv
module rfrx_shift #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             load_en,
  output logic [NBITS-1:0] data_out
);

  logic [NBITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      data_out <= '0;
    end else begin
      if (shift_en) begin
        sr <= {bit_in, sr[NBITS-1:1]};
      end
      if (load_en) begin
        data_out <= sr;
      end
    end
  end

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(data_out));

endmodule

// File: rtl/rfrx_ctrl.sv
module rfrx_ctrl
  import rfrx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int NBITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd,
  output logic shift_en,
  output logic load_en,
  output logic frame_ok,
  output logic frame_bad
);

  localparam int CW   = $clog2(OVS);
  localparam int BW   = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int MIDT = mid_tick(OVS);
  localparam int ENDT = end_tick(OVS);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;

  logic at_mid;
  logic at_end;
  logic stop_sample;

  assign at_mid      = tick && (cnt == CW'(MIDT));
  assign at_end      = tick && (cnt == CW'(ENDT));
  assign shift_en    = (st == ST_DATA) && at_end;
  assign stop_sample = (st == ST_STOP) && at_end;
  assign load_en     = stop_sample && rxd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_HUNT;
      cnt       <= '0;
      bidx      <= '0;
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
      case (st)
        ST_HUNT: begin
          if (tick && !rxd) begin
            st  <= ST_CONFIRM;
            cnt <= '0;
          end
        end
        ST_CONFIRM: begin
          if (at_mid) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rxd ? ST_HUNT : ST_DATA;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (at_end) begin
            cnt <= '0;
            if (bidx == BW'(NBITS - 1)) begin
              st <= ST_STOP;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_end) begin
            cnt <= '0;
            if (rxd) begin
              frame_ok <= 1'b1;
              st       <= ST_HUNT;
            end else begin
              frame_bad <= 1'b1;
              st        <= ST_RECOVER;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RECOVER: begin
          if (tick && rxd) begin
            st <= ST_HUNT;
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok && frame_bad));

  p_ok_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !frame_ok);

  p_bad_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    frame_bad |=> !frame_bad);

  p_bad_enters_recover_r5: assert property (@(posedge clk) disable iff (rst)
    frame_bad |-> (st == ST_RECOVER));

  p_recover_waits_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECOVER && !rxd) |=> (st == ST_RECOVER));

  p_resume_hunt_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECOVER && tick && rxd) |=> (st == ST_HUNT));

  p_confirm_from_hunt_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CONFIRM && $past(st) != ST_CONFIRM) |->
      ($past(st) == ST_HUNT && !$past(rxd)));

endmodule

// File: rtl/rf_uart_rx.sv
module rf_uart_rx #(
  parameter int OVS      = 16,
  parameter int TICK_DIV = 1,
  parameter int NBITS    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_line,
  output logic [NBITS-1:0] rx_byte,
  output logic             rx_valid,
  output logic             rx_frame_err
);

  logic tick;
  logic shift_en;
  logic load_en;

  rfrx_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rfrx_ctrl #(.OVS(OVS), .NBITS(NBITS)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rxd       (rx_line),
    .shift_en  (shift_en),
    .load_en   (load_en),
    .frame_ok  (rx_valid),
    .frame_bad (rx_frame_err)
  );

  rfrx_shift #(.NBITS(NBITS)) i_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (rx_line),
    .load_en  (load_en),
    .data_out (rx_byte)
  );

  p_byte_on_valid_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(load_en));

endmodule

// File: tb/test_rf_uart_rx.sv
`timescale 1ns/1ps
module test_rf_uart_rx;

  localparam int OVS = 16;
  localparam int LAT = OVS / 2 + 9 * OVS + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       rx_frame_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_valid = 0;
  int n_ferr  = 0;
  int last_valid_cyc = 0;
  logic [7:0] last_byte = 8'h00;
  logic prev_valid = 1'b0;
  logic prev_ferr  = 1'b0;
  int long_valid = 0;
  int long_ferr  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rf_uart_rx #(.OVS(OVS), .TICK_DIV(1), .NBITS(8)) i_rf_uart_rx (
    .clk          (clk),
    .rst          (rst),
    .rx_line      (rx_line),
    .rx_byte      (rx_byte),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      n_valid        <= n_valid + 1;
      last_byte      <= rx_byte;
      last_valid_cyc <= cyc;
      if (prev_valid) long_valid <= long_valid + 1;
    end
    if (rx_frame_err) begin
      n_ferr <= n_ferr + 1;
      if (prev_ferr) long_ferr <= long_ferr + 1;
    end
    prev_valid <= rx_valid;
    prev_ferr  <= rx_frame_err;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int clocks);
    rx_line = b;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop_bit);
    send_bit(1'b0, OVS);
    for (int i = 0; i < 8; i++) send_bit(d[i], OVS);
    send_bit(stop_bit, OVS);
  endtask

  function automatic logic [7:0] align_byte(input int k, input logic [7:0] payload);
    case (k)
      0, 1, 2: return 8'h55;
      3:       return 8'h44;
      4:       return 8'h11;
      5:       return 8'h45;
      6:       return 8'h15;
      default: return payload;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v0, f0, start_cyc;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rx_valid == 1'b0, "R1 valid low in reset", rx_valid, 0);
    check(rx_frame_err == 1'b0, "R1 ferr low in reset", rx_frame_err, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rx_byte == 8'h00, "R1 byte cleared", rx_byte, 0);

    // R1/R3: first frame right after reset, exact strobe timing
    start_cyc = cyc;
    v0 = n_valid;
    send_frame(8'hB4, 1'b1);
    send_bit(1'b1, 8);
    check(n_valid == v0 + 1, "R1 frame after reset received", n_valid - v0, 1);
    check(last_byte == 8'hB4, "R1 byte after reset", last_byte, 8'hB4);
    check(last_valid_cyc - start_cyc == LAT, "R3 valid strobe timing",
          last_valid_cyc - start_cyc, LAT);

    // R2/R3: sweep of every byte value
    for (int d = 0; d < 256; d++) begin
      v0 = n_valid;
      send_frame(d[7:0], 1'b1);
      send_bit(1'b1, 4);
      check(n_valid == v0 + 1 && last_byte == d[7:0], "R2 byte sweep", last_byte, d);
    end
    check(long_valid == 0, "R3 valid is one clock wide", long_valid, 0);

    // R4: low stop bit
    v0 = n_valid;
    f0 = n_ferr;
    send_frame(8'h5A, 1'b0);
    // R5: line held low for a long time
    send_bit(1'b0, 40 * OVS);
    check(n_ferr == f0 + 1, "R4 single framing error", n_ferr - f0, 1);
    check(n_valid == v0, "R4 no valid for bad frame", n_valid - v0, 0);
    check(long_ferr == 0, "R4 ferr is one clock wide", long_ferr, 0);
    check(n_ferr == f0 + 1 && n_valid == v0, "R5 no frame while line low",
          n_ferr - f0 + n_valid - v0, 1);
    check(last_byte == 8'hFF, "R2 byte held after error", last_byte, 8'hFF);

    // R6: two clocks of high line, then a frame straight away
    send_bit(1'b1, 2);
    send_frame(8'h3C, 1'b1);
    send_bit(1'b1, 8);
    check(n_valid == v0 + 1 && last_byte == 8'h3C, "R6 resume hunting immediately",
          last_byte, 8'h3C);

    // R7: glitches of various lengths shorter than half a bit
    for (int g = 1; g < OVS / 2; g++) begin
      v0 = n_valid;
      f0 = n_ferr;
      send_bit(1'b0, g);
      send_bit(1'b1, 12 * OVS);
      check(n_valid == v0 && n_ferr == f0, "R7 glitch ignored", n_valid - v0 + n_ferr - f0, 0);
    end
    v0 = n_valid;
    send_frame(8'hE1, 1'b1);
    send_bit(1'b1, 4);
    check(n_valid == v0 + 1 && last_byte == 8'hE1, "R7 frame after glitches", last_byte, 8'hE1);

    // R8: alignment sequence from every release point
    for (int off = 0; off < 20; off++) begin
      logic [7:0] payload;
      logic [7:0] cur;
      payload = 8'hA0 + off[7:0];
      rst = 1'b1;
      rx_line = 1'b1;
      repeat (3) @(negedge clk);
      v0 = n_valid;
      for (int k = 0; k < 8; k++) begin
        cur = align_byte(k, payload);
        for (int p = 0; p < 10; p++) begin
          logic b;
          b = (p == 0) ? 1'b0 : ((p == 9) ? 1'b1 : cur[p - 1]);
          rx_line = b;
          for (int c = 0; c < OVS; c++) begin
            if (k * 10 + p == off && c == 2) rst = 1'b0;
            @(negedge clk);
          end
        end
      end
      send_bit(1'b1, 2 * OVS);
      check(n_valid > v0 && last_byte == payload, "R8 alignment steering",
            last_byte, payload);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule